// File: doc/BRIEF.md
# Boot-Overlay Chip-Select Decoder

This block turns the 16-bit address bus of an 8-bit processor into active-low chip selects for a RAM, a small boot ROM, an I/O region and two expansion regions. It also produces a RAM write strobe. The address space is cut into eight 8 KiB slices on the three top address bits. A boot-mode bit decides how the slices are mapped.

While boot mode is on, the top slice works as a split window. Reads there fetch from the boot ROM, and writes there fall through to the RAM underneath. Loader code running from ROM can therefore fill the RAM behind itself, including the RAM copy of the reset and interrupt vectors. When the loader clears the boot bit, the ROM drops out of the map. RAM then covers everything except the I/O slice, so the next processor reset fetches its vectors from RAM.

The boot bit has two sources:
- A write-only control location inside the I/O slice. The value written is carried by address bit 0.
- An external strap pin, which forces boot mode.

A power-on reset sets the bit. A processor-only reset leaves it untouched.

Top module: `boot_overlay_dec`

## Requirements
- R1: With boot mode on and `vld` high, slices 0..3 ($0000-$7FFF) select RAM, slice 4 ($8000-$9FFF) selects expansion 0, slice 5 ($A000-$BFFF) selects expansion 1, and slice 6 ($C000-$DFFF) selects I/O. This holds for reads and writes alike.
- R2: With boot mode on, a read in slice 7 ($E000-$FFFF) selects only the boot ROM. A write in slice 7 selects only the RAM and asserts its write strobe.
- R3: With boot mode off, the boot ROM is never selected. Slice 6 selects I/O, and every other slice (0..5 and 7) selects RAM.
- R4: With boot mode off and `wp_en` high, a write in slice 7 asserts no select and no write strobe, while reads there still select RAM. With boot mode on, `wp_en` has no effect.
- R5: `ram_we_n` is low exactly when `ram_cs_n` is low during a write cycle (`rnw` = 0).
- R6: With `vld` low, every select and the write strobe stay high.
- R7: At most one of the five device selects is low at any time.
- R8: The power-on reset `por` (synchronous, active high) sets the boot bit to 1. `cpu_rst` never changes the boot bit.
- R9: A valid write cycle to $DF00 or $DF01, with `cpu_rst` low, loads address bit 0 into the boot bit (0 = off, 1 = on). The new mode is in effect from the next clock edge onward. Reads of these addresses, and writes to them while `cpu_rst` is high, leave the bit unchanged.
- R10: `boot_strap` high forces boot mode on, whatever the stored bit holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the boot-bit register |
| por | input | 1 | Power-on reset, synchronous, active high; sets boot mode |
| cpu_rst | input | 1 | Processor reset, active high; blocks control writes, keeps boot bit |
| addr | input | 16 | Processor address bus |
| rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| vld | input | 1 | High while the bus cycle is valid |
| boot_strap | input | 1 | External pin forcing boot mode |
| wp_en | input | 1 | Enables write protection of slice 7 when boot mode is off |
| ram_cs_n | output | 1 | RAM select, active low |
| rom_cs_n | output | 1 | Boot ROM select, active low |
| io_cs_n | output | 1 | I/O region select, active low |
| x0_cs_n | output | 1 | Expansion region 0 select, active low |
| x1_cs_n | output | 1 | Expansion region 1 select, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |

## Verification
All selects and the write strobe are combinational from the address, `rnw`, `vld`, `wp_en`, the strap and the stored boot bit, so they are due in the same cycle as the bus inputs. The bench drives the bus on the falling edge and compares 1 ns later, before any rising edge.

A control write or reset changes the stored bit at the rising edge that follows it, so the bench reads the new mode from the next falling edge on. It reads slice 7: a ROM select means boot mode is on, a RAM select means it is off.

The map is swept over every slice, both ends of each slice, both rnw values, both protect settings and both boot states. Each result is compared with a table the bench computes itself.

// File: rtl/bod_pkg.sv
package bod_pkg;

    // Device chosen for one bus cycle.
    typedef enum logic [2:0] {
        DEV_NONE,
        DEV_RAM,
        DEV_ROM,
        DEV_IO,
        DEV_X0,
        DEV_X1
    } dev_e;

    // Internal active-high select bundle.
    typedef struct packed {
        logic ram;
        logic rom;
        logic io;
        logic x0;
        logic x1;
        logic we;
    } sel_t;

    // Slices are counted from the top of the map:
    //   nsl-1 : ROM window
    //   nsl-2 : I/O
    //   nsl-3 : expansion 1
    //   nsl-4 : expansion 0
    //   below : RAM in every mode
    function automatic dev_e pick_dev(
        input int unsigned idx,
        input int unsigned nsl,
        input logic        boot,
        input logic        rd,
        input logic        wp
    );
        dev_e d;
        if (idx == nsl - 1) begin
            if (boot)
                d = rd ? DEV_ROM : DEV_RAM;
            else if (!rd && wp)
                d = DEV_NONE;
            else
                d = DEV_RAM;
        end else if (idx == nsl - 2) begin
            d = DEV_IO;
        end else if (boot && idx == nsl - 3) begin
            d = DEV_X1;
        end else if (boot && idx == nsl - 4) begin
            d = DEV_X0;
        end else begin
            d = DEV_RAM;
        end
        return d;
    endfunction

    function automatic sel_t dev_to_sel(input dev_e d, input logic rd);
        sel_t s;
        s     = '0;
        s.ram = (d == DEV_RAM);
        s.rom = (d == DEV_ROM);
        s.io  = (d == DEV_IO);
        s.x0  = (d == DEV_X0);
        s.x1  = (d == DEV_X1);
        s.we  = (d == DEV_RAM) && !rd;
        return s;
    endfunction

endpackage

// File: rtl/bod_boot_ctl.sv
module bod_boot_ctl #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hDF00
) (
    input  logic              clk,
    input  logic              por,
    input  logic              cpu_rst,
    input  logic              vld,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strap,
    output logic              boot_q,
    output logic              boot
);
    // The control location is a pair of addresses; bit 0 carries the value.
    logic hit;

    assign hit = vld && !rd && !cpu_rst &&
                 (addr[ADDR_W-1:1] == CTRL_ADDR[ADDR_W-1:1]);

    always_ff @(posedge clk) begin
        if (por)
            boot_q <= 1'b1;
        else if (hit)
            boot_q <= addr[0];
    end

    assign boot = boot_q | strap;
endmodule

// File: rtl/bod_slice_table.sv
module bod_slice_table
    import bod_pkg::*;
#(
    parameter int NUM_SLICES = 8
) (
    input  logic boot,
    input  logic rd,
    input  logic wp,
    output dev_e tbl [NUM_SLICES]
);
    // One device entry per slice for the present mode and direction.
    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
        assign tbl[i] = pick_dev(i, NUM_SLICES, boot, rd, wp);
    end
endmodule

// File: rtl/bod_sel_mux.sv
module bod_sel_mux
    import bod_pkg::*;
#(
    parameter int SLICE_W    = 3,
    parameter int NUM_SLICES = 1 << SLICE_W
) (
    input  logic               vld,
    input  logic               rd,
    input  logic [SLICE_W-1:0] slice,
    input  dev_e               tbl [NUM_SLICES],
    output sel_t               sel
);
    dev_e dev;

    always_comb begin
        dev = vld ? tbl[slice] : DEV_NONE;
        sel = dev_to_sel(dev, rd);
    end
endmodule

// File: rtl/boot_overlay_dec.sv
module boot_overlay_dec
    import bod_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                SLICE_W   = 3,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hDF00
) (
    input  logic              clk,
    input  logic              por,
    input  logic              cpu_rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rnw,
    input  logic              vld,
    input  logic              boot_strap,
    input  logic              wp_en,
    output logic              ram_cs_n,
    output logic              rom_cs_n,
    output logic              io_cs_n,
    output logic              x0_cs_n,
    output logic              x1_cs_n,
    output logic              ram_we_n
);
    localparam int NUM_SLICES = 1 << SLICE_W;

    logic               boot_q;
    logic               boot;
    logic [SLICE_W-1:0] slice;
    dev_e               tbl [NUM_SLICES];
    sel_t               sel;

    assign slice = addr[ADDR_W-1 -: SLICE_W];

    bod_boot_ctl #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_ctl (
        .clk    (clk),
        .por    (por),
        .cpu_rst(cpu_rst),
        .vld    (vld),
        .rd     (rnw),
        .addr   (addr),
        .strap  (boot_strap),
        .boot_q (boot_q),
        .boot   (boot)
    );

    bod_slice_table #(
        .NUM_SLICES(NUM_SLICES)
    ) u_tbl (
        .boot(boot),
        .rd  (rnw),
        .wp  (wp_en),
        .tbl (tbl)
    );

    bod_sel_mux #(
        .SLICE_W   (SLICE_W),
        .NUM_SLICES(NUM_SLICES)
    ) u_mux (
        .vld  (vld),
        .rd   (rnw),
        .slice(slice),
        .tbl  (tbl),
        .sel  (sel)
    );

    assign ram_cs_n = ~sel.ram;
    assign rom_cs_n = ~sel.rom;
    assign io_cs_n  = ~sel.io;
    assign x0_cs_n  = ~sel.x0;
    assign x1_cs_n  = ~sel.x1;
    assign ram_we_n = ~sel.we;
endmodule

// File: rtl/bod_checker.sv
module bod_checker #(
    parameter int ADDR_W  = 16,
    parameter int SLICE_W = 3
) (
    input logic              clk,
    input logic              por,
    input logic              cpu_rst,
    input logic              vld,
    input logic              rnw,
    input logic [ADDR_W-1:0] addr,
    input logic              wp_en,
    input logic              boot,
    input logic              boot_q,
    input logic              ram_cs_n,
    input logic              rom_cs_n,
    input logic              io_cs_n,
    input logic              x0_cs_n,
    input logic              x1_cs_n,
    input logic              ram_we_n
);
    localparam logic [SLICE_W-1:0] SL_TOP = '1;
    localparam logic [SLICE_W-1:0] SL_IO  = SL_TOP - 1'b1;

    logic [SLICE_W-1:0] sl;
    assign sl = addr[ADDR_W-1 -: SLICE_W];

    AST_IO_SLICE: assert property (@(posedge clk) disable iff (por)
        (vld && sl == SL_IO) |-> !io_cs_n); // R1
    AST_ROM_BOOT_READ: assert property (@(posedge clk) disable iff (por)
        !rom_cs_n |-> (boot && rnw && sl == SL_TOP)); // R2
    AST_NO_ROM_AFTER_BOOT: assert property (@(posedge clk) disable iff (por)
        !boot |-> rom_cs_n); // R3
    AST_PROTECTED_WRITE: assert property (@(posedge clk) disable iff (por)
        (vld && !rnw && !boot && wp_en && sl == SL_TOP) |-> (ram_we_n && ram_cs_n)); // R4
    AST_WE_ON_RAM_WRITE: assert property (@(posedge clk) disable iff (por)
        !ram_we_n |-> (!ram_cs_n && !rnw)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (por)
        !vld |-> (ram_cs_n && rom_cs_n && io_cs_n && x0_cs_n && x1_cs_n && ram_we_n)); // R6
    AST_ONE_DEVICE: assert property (@(posedge clk) disable iff (por)
        $countones({~ram_cs_n, ~rom_cs_n, ~io_cs_n, ~x0_cs_n, ~x1_cs_n}) <= 1); // R7
    AST_CPU_RST_HOLDS: assert property (@(posedge clk) disable iff (por)
        (cpu_rst && !por) |=> $stable(boot_q)); // R8
    AST_POR_SETS_BOOT: assert property (@(posedge clk)
        por |=> boot_q); // R8
endmodule

bind boot_overlay_dec bod_checker #(
    .ADDR_W (ADDR_W),
    .SLICE_W(SLICE_W)
) u_chk (
    .clk     (clk),
    .por     (por),
    .cpu_rst (cpu_rst),
    .vld     (vld),
    .rnw     (rnw),
    .addr    (addr),
    .wp_en   (wp_en),
    .boot    (boot),
    .boot_q  (boot_q),
    .ram_cs_n(ram_cs_n),
    .rom_cs_n(rom_cs_n),
    .io_cs_n (io_cs_n),
    .x0_cs_n (x0_cs_n),
    .x1_cs_n (x1_cs_n),
    .ram_we_n(ram_we_n)
);

// File: tb/tb_boot_overlay_dec.sv
`timescale 1ns/1ps
module tb_boot_overlay_dec;
    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        cpu_rst = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        rnw = 1'b1;
    logic        vld = 1'b0;
    logic        boot_strap = 1'b0;
    logic        wp_en = 1'b0;
    logic        ram_cs_n, rom_cs_n, io_cs_n, x0_cs_n, x1_cs_n, ram_we_n;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    boot_overlay_dec dut (
        .clk       (clk),
        .por       (por),
        .cpu_rst   (cpu_rst),
        .addr      (addr),
        .rnw       (rnw),
        .vld       (vld),
        .boot_strap(boot_strap),
        .wp_en     (wp_en),
        .ram_cs_n  (ram_cs_n),
        .rom_cs_n  (rom_cs_n),
        .io_cs_n   (io_cs_n),
        .x0_cs_n   (x0_cs_n),
        .x1_cs_n   (x1_cs_n),
        .ram_we_n  (ram_we_n)
    );

    // Output vector order: {ram, rom, io, x0, x1, we}, all active low.
    function automatic logic [5:0] expect_vec(int sl, bit boot, bit rd, bit wp, bit v);
        logic [5:0] e;
        e = 6'b111111;
        if (!v) return e;
        case (sl)
            6: e[3] = 1'b0;
            7: begin
                if (boot && rd)            e[4] = 1'b0;
                else if (!boot && !rd && wp) e = 6'b111111;
                else                       e[5] = 1'b0;
            end
            4: if (boot) e[2] = 1'b0; else e[5] = 1'b0;
            5: if (boot) e[1] = 1'b0; else e[5] = 1'b0;
            default: e[5] = 1'b0;
        endcase
        if (!e[5] && !rd) e[0] = 1'b0;
        return e;
    endfunction

    function automatic logic [5:0] outs();
        return {ram_cs_n, rom_cs_n, io_cs_n, x0_cs_n, x1_cs_n, ram_we_n};
    endfunction

    task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h rnw=%0b act=%b exp=%b", req, addr, rnw, act, exp);
        end
    endtask

    // Drive a bus cycle at the falling edge and sample 1 ns later.
    task automatic probe(logic [15:0] a, bit rd, bit v);
        @(negedge clk);
        addr = a; rnw = rd; vld = v;
        #1;
    endtask

    task automatic ctrl_write(logic [15:0] a);
        @(negedge clk);
        addr = a; rnw = 1'b0; vld = 1'b1;
        @(negedge clk);
        vld = 1'b0; rnw = 1'b1;
    endtask

    task automatic sweep(bit boot, string req);
        for (int w = 0; w < 2; w++) begin
            wp_en = w[0];
            for (int r = 0; r < 2; r++) begin
                for (int sl = 0; sl < 8; sl++) begin
                    for (int k = 0; k < 2; k++) begin
                        logic [15:0] a;
                        a = 16'(sl << 13) | (k == 0 ? 16'h0000 : 16'h1FFF);
                        probe(a, r[0], 1'b1);
                        chk(req, outs(), expect_vec(sl, boot, r[0], w[0], 1'b1));
                    end
                end
            end
        end
        wp_en = 1'b0;
        vld = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); por = 1'b0;

        // R6 reset/idle state
        probe(16'hFFFC, 1'b1, 1'b0);
        chk("R6 idle after reset", outs(), 6'b111111);
        // R8 power-on reset leaves boot mode on
        probe(16'hFFFC, 1'b1, 1'b1);
        chk("R8 por sets boot", outs(), expect_vec(7, 1, 1, 0, 1));

        // R1 R2 R4 R5 R7 boot-mode map
        sweep(1'b1, "R1/R2/R4/R5 boot map");

        // R9 clear boot through the control location
        ctrl_write(16'hDF00);
        probe(16'hFFFC, 1'b1, 1'b1);
        chk("R9 ctrl clear", outs(), expect_vec(7, 0, 1, 0, 1));

        // R3 R4 R5 run map
        sweep(1'b0, "R3/R4/R5 run map");

        // R6 vld low over every slice and direction
        for (int sl = 0; sl < 8; sl++)
            for (int r = 0; r < 2; r++) begin
                probe(16'(sl << 13) | 16'h0123, r[0], 1'b0);
                chk("R6 vld low", outs(), 6'b111111);
            end

        // R8 R9 cpu reset keeps the bit and blocks control writes
        @(negedge clk); cpu_rst = 1'b1;
        ctrl_write(16'hDF01);
        repeat (3) @(negedge clk);
        cpu_rst = 1'b0;
        probe(16'hFFFE, 1'b1, 1'b1);
        chk("R8 cpu_rst keeps boot off", outs(), expect_vec(7, 0, 1, 0, 1));

        // R9 a read of the control location changes nothing
        probe(16'hDF01, 1'b1, 1'b1);
        chk("R9 ctrl read is io", outs(), expect_vec(6, 0, 1, 0, 1));
        probe(16'hFFFC, 1'b1, 1'b1);
        chk("R9 ctrl read no effect", outs(), expect_vec(7, 0, 1, 0, 1));

        // R10 strap forces boot mode
        @(negedge clk); boot_strap = 1'b1;
        probe(16'hFFFC, 1'b1, 1'b1);
        chk("R10 strap forces rom", outs(), expect_vec(7, 1, 1, 0, 1));
        probe(16'hE000, 1'b0, 1'b1);
        wp_en = 1'b1; #0.5;
        chk("R10 strap write hits ram", outs(), expect_vec(7, 1, 0, 1, 1));
        wp_en = 1'b0;
        @(negedge clk); boot_strap = 1'b0; vld = 1'b0;
        probe(16'hFFFC, 1'b1, 1'b1);
        chk("R10 strap released", outs(), expect_vec(7, 0, 1, 0, 1));

        // R9 set boot again through the control location
        ctrl_write(16'hDF01);
        probe(16'hFFFC, 1'b1, 1'b1);
        chk("R9 ctrl set", outs(), expect_vec(7, 1, 1, 0, 1));

        // R8 cpu reset keeps boot on as well
        @(negedge clk); cpu_rst = 1'b1; vld = 1'b0;
        repeat (2) @(negedge clk);
        cpu_rst = 1'b0;
        probe(16'hFFFC, 1'b1, 1'b1);
        chk("R8 cpu_rst keeps boot on", outs(), expect_vec(7, 1, 1, 0, 1));

        // R8 power-on reset restores boot mode after clear
        ctrl_write(16'hDF00);
        probe(16'hFFFC, 1'b1, 1'b1);
        chk("R9 ctrl clear again", outs(), expect_vec(7, 0, 1, 0, 1));
        @(negedge clk); vld = 1'b0; por = 1'b1;
        @(negedge clk); por = 1'b0;
        probe(16'hFFFC, 1'b1, 1'b1);
        chk("R8 por restores boot", outs(), expect_vec(7, 1, 1, 0, 1));

        @(negedge clk); vld = 1'b0;
        summary();
    end
endmodule